// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a single-byte SPI master that a host CPU runs through a small byte-wide register file. The host picks clock polarity, clock phase and bit order in a control register, and sets the serial clock rate with a prescaler and a power-of-two exponent in a baud register. It starts each transfer by writing one byte to the data register. When the byte has shifted out and the reply byte has shifted in, a done flag is raised. The host reads the reply byte back from the same data address.

Status flags clear only through fixed access sequences, never by writing to the status register. A write to the data register while a byte is still shifting is dropped and raises a collision flag. If the external slave-select input goes low while the block is an enabled master, it raises a fault flag, leaves master mode and releases its clock and data outputs. A general-purpose output port, with its own data and direction registers, carries the slave-select line that the host drives by software. The done flag and the fault flag each have their own interrupt line, and both lines are gated by one enable bit.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0x00, SCK is low, the SCK, MOSI and port drivers are released, and both interrupt outputs are low.
- R2: A data write (offset 0x09) while control bits 6 (enable) and 4 (master) are set and no byte is shifting starts a transfer of exactly 16 SCK edges. The half period is (P+1)·2^E bus clocks, with P in baud bits [6:4] and E in baud bits [2:0] (offset 0x04). The first edge comes one half period after the write.
- R3: When idle, SCK rests at control bit 3. Bits go out most-significant first when control bit 0 is 0, and least-significant first when it is 1.
- R4: With control bit 2 at 0, MOSI holds the first bit before the first edge and MISO is sampled on odd edges. With bit 2 at 1, MISO is sampled on even edges. The received byte is read at offset 0x09.
- R5: Status bit 7 sets when a transfer ends. It clears only when a status read (offset 0x05) that sees it set is followed by a data read. A data read with no such status read before it leaves the bit set.
- R6: A data write during a transfer sets status bit 6 and is dropped, and the ongoing byte is not disturbed. Bit 6 clears when a status read that sees it set is followed by any data-register access.
- R7: While an enabled master sees the slave-select input low, status bit 4 sets, control bits 6 and 4 clear, any transfer is aborted, and the SCK and MOSI drivers are released. Bit 4 clears when a status read that sees it set is followed by a control write (offset 0x00).
- R8: The done and fault interrupt outputs follow status bits 7 and 4 only while control bit 7 is set.
- R9: A data write while control bit 6 or bit 4 is clear starts nothing: no SCK edge, no flag, and the received byte is unchanged.
- R10: The port data register (offset 0x0D) drives the port pins, and the port direction register (offset 0x10) drives the port enables. Writing 0x08 to port data sets pin 3, which deasserts the active-low slave select, and writing 0x00 clears it.
- R11: When the end of a transfer falls in the same cycle as the data read that completes the status bit 7 clear sequence, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Serial data out driver enable |
| miso_i | input | 1 | Serial data in |
| ss_ni | input | 1 | External slave-select sense, active low |
| port_o | output | 8 | General-purpose port pins (pin 3 is slave select) |
| port_oe_o | output | 8 | General-purpose port driver enables |
| done_irq_o | output | 1 | Transfer-done interrupt |
| fault_irq_o | output | 1 | Mode-fault interrupt |

## Verification
The end of a transfer, which sets the done flag, can fall in the same cycle as the data read that finishes that flag's clear sequence. The bench sets up this collision at the fastest rate, where the 16th edge lands exactly 16 cycles after the data write. It arms the clear with a status read, starts a second byte, and places the data read on that 16th cycle. The status register must then still show the done flag, and a fresh status-then-data sequence must clear it afterwards.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_CTRL2 = 'h01;
  localparam int unsigned OFS_BAUD  = 'h04;
  localparam int unsigned OFS_STAT  = 'h05;
  localparam int unsigned OFS_DATA  = 'h09;
  localparam int unsigned OFS_PDAT  = 'h0D;
  localparam int unsigned OFS_PDIR  = 'h10;

  localparam int unsigned C_IRQEN = 7;
  localparam int unsigned C_EN    = 6;
  localparam int unsigned C_MSTR  = 4;
  localparam int unsigned C_CPOL  = 3;
  localparam int unsigned C_CPHA  = 2;
  localparam int unsigned C_LSB   = 0;

  localparam int unsigned S_DONE  = 7;
  localparam int unsigned S_COLL  = 6;
  localparam int unsigned S_FAULT = 4;

  localparam int unsigned BAUD_PRE_LSB = 4;
  localparam int unsigned BAUD_EXP_LSB = 0;

  localparam int unsigned F_DONE  = 0;
  localparam int unsigned F_COLL  = 1;
  localparam int unsigned F_FAULT = 2;
  localparam int unsigned NFLAG   = 3;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned PRE_W = 3,
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] cnt_q;

  // half period = (pre+1) << exp bus clocks
  assign half_w = (CNT_W'(pre_i) + CNT_W'(1)) << exp_i;
  assign tick_o = run_i && (cnt_q == half_w - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (half_w > CNT_W'(1)) && $stable(half_w) |=> !tick_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          tick_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic [DW-1:0] tx_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned NEDGE = 2 * DW;
  localparam int unsigned EW    = $clog2(NEDGE);
  localparam logic [EW-1:0] LAST = EW'(NEDGE - 1);

  logic          busy_q, sck_q, smp_q;
  logic [EW-1:0] ecnt_q;
  logic [DW-1:0] sh_q, rx_q;
  logic          step_w, last_w, samp_w;

  function automatic logic [DW-1:0] push(input logic [DW-1:0] v, input logic b,
                                         input logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  assign step_w = busy_q && tick_i;
  assign last_w = (ecnt_q == LAST);
  // ecnt_q even -> the coming edge is a leading one
  assign samp_w = cpha_i ? ecnt_q[0] : ~ecnt_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      smp_q  <= 1'b0;
      ecnt_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sck_q  <= cpol_i;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      ecnt_q <= '0;
      sh_q   <= tx_i;
      sck_q  <= cpol_i;
    end else if (step_w) begin
      sck_q  <= ~sck_q;
      ecnt_q <= ecnt_q + EW'(1);
      if (last_w) begin
        busy_q <= 1'b0;
        rx_q   <= push(sh_q, cpha_i ? miso_i : smp_q, lsb_i);
      end else if (samp_w) begin
        smp_q <= miso_i;
      end else if (!(cpha_i && ecnt_q == '0)) begin
        sh_q <= push(sh_q, smp_q, lsb_i);
      end
    end else if (!busy_q) begin
      sck_q <= cpol_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = step_w && last_w && !abort_i;
  assign sck_o  = sck_q;
  assign mosi_o = lsb_i ? sh_q[0] : sh_q[DW-1];
  assign rx_o   = rx_q;

  a_r3_sck_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(busy_o) && $stable(cpol_i) && !$past(start_i) |-> sck_o == cpol_i);
  a_r2_sck_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i && !abort_i |=> $stable(sck_o));
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
  parameter int unsigned NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_evt_i,
  input  logic          stat_rd_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] arm_q, flag_q;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arm_q[k]  <= 1'b0;
        flag_q[k] <= 1'b0;
      end else begin
        if (stat_rd_i && flag_q[k]) arm_q[k] <= 1'b1;
        else if (clr_evt_i[k])      arm_q[k] <= 1'b0;
        // a new set outranks a clear in the same cycle
        if (set_i[k])                       flag_q[k] <= 1'b1;
        else if (arm_q[k] && clr_evt_i[k])  flag_q[k] <= 1'b0;
      end
    end

    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    a_r5_clear_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[k]) |-> $past(clr_evt_i[k]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned PRE_W       = 3,
  parameter int unsigned EXP_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  input  logic              ss_ni,
  output logic [DW-1:0]     port_o,
  output logic [DW-1:0]     port_oe_o,
  output logic              done_irq_o,
  output logic              fault_irq_o
);
  localparam logic [DW-1:0] BAUD_MASK =
    DW'(((1 << PRE_W) - 1) << BAUD_PRE_LSB) | DW'(((1 << EXP_W) - 1) << BAUD_EXP_LSB);

  logic [DW-1:0] ctrl_q, ctrl2_q, baud_q, pdat_q, pdir_q, ctrl_d, stat_w;
  logic [SYNC_STAGES-1:0] ss_pipe_q;
  logic ss_low_w, mstr_on_w;
  logic ctrl_wr_w, data_wr_w, data_rd_w, stat_rd_w;
  logic start_w, abort_w, coll_set_w, fault_set_w;
  logic busy_w, done_w, tick_w;
  logic [DW-1:0] rx_w;
  logic [NFLAG-1:0] flag_set_w, flag_clr_w, flags_w;

  // access decode
  assign ctrl_wr_w = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign data_wr_w = wr_en_i && (addr_i == ADDR_W'(OFS_DATA));
  assign data_rd_w = rd_en_i && (addr_i == ADDR_W'(OFS_DATA));
  assign stat_rd_w = rd_en_i && (addr_i == ADDR_W'(OFS_STAT));

  // slave-select sense synchronizer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ss_pipe_q <= '1;
    else         ss_pipe_q <= {ss_pipe_q[SYNC_STAGES-2:0], ss_ni};
  end
  assign ss_low_w = ~ss_pipe_q[SYNC_STAGES-1];

  assign mstr_on_w   = ctrl_q[C_EN] && ctrl_q[C_MSTR];
  assign fault_set_w = mstr_on_w && ss_low_w;
  assign start_w     = data_wr_w && mstr_on_w && !busy_w;
  assign coll_set_w  = data_wr_w && busy_w;
  assign abort_w     = busy_w && !mstr_on_w;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr_w) ctrl_d = wdata_i;
    if (fault_set_w) begin
      ctrl_d[C_EN]   = 1'b0;
      ctrl_d[C_MSTR] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
      baud_q  <= '0;
      pdat_q  <= '0;
      pdir_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en_i) begin
        if (addr_i == ADDR_W'(OFS_CTRL2)) ctrl2_q <= wdata_i;
        if (addr_i == ADDR_W'(OFS_BAUD))  baud_q  <= wdata_i & BAUD_MASK;
        if (addr_i == ADDR_W'(OFS_PDAT))  pdat_q  <= wdata_i;
        if (addr_i == ADDR_W'(OFS_PDIR))  pdir_q  <= wdata_i;
      end
    end
  end

  spi_baud_gen #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .pre_i  (baud_q[BAUD_PRE_LSB +: PRE_W]),
    .exp_i  (baud_q[BAUD_EXP_LSB +: EXP_W]),
    .tick_o (tick_w)
  );

  spi_shift_engine #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .abort_i (abort_w),
    .tick_i  (tick_w),
    .cpol_i  (ctrl_q[C_CPOL]),
    .cpha_i  (ctrl_q[C_CPHA]),
    .lsb_i   (ctrl_q[C_LSB]),
    .tx_i    (wdata_i),
    .miso_i  (miso_i),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (rx_w)
  );

  always_comb begin
    flag_set_w          = '0;
    flag_set_w[F_DONE]  = done_w;
    flag_set_w[F_COLL]  = coll_set_w;
    flag_set_w[F_FAULT] = fault_set_w;
    flag_clr_w          = '0;
    flag_clr_w[F_DONE]  = data_rd_w;
    flag_clr_w[F_COLL]  = data_rd_w || data_wr_w;
    flag_clr_w[F_FAULT] = ctrl_wr_w;
  end

  spi_flag_bank #(.NF(NFLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (flag_set_w),
    .clr_evt_i (flag_clr_w),
    .stat_rd_i (stat_rd_w),
    .flag_o    (flags_w)
  );

  always_comb begin
    stat_w          = '0;
    stat_w[S_DONE]  = flags_w[F_DONE];
    stat_w[S_COLL]  = flags_w[F_COLL];
    stat_w[S_FAULT] = flags_w[F_FAULT];
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_CTRL):  rdata_o = ctrl_q;
      ADDR_W'(OFS_CTRL2): rdata_o = ctrl2_q;
      ADDR_W'(OFS_BAUD):  rdata_o = baud_q;
      ADDR_W'(OFS_STAT):  rdata_o = stat_w;
      ADDR_W'(OFS_DATA):  rdata_o = rx_w;
      ADDR_W'(OFS_PDAT):  rdata_o = pdat_q;
      ADDR_W'(OFS_PDIR):  rdata_o = pdir_q;
      default:            rdata_o = '0;
    endcase
  end

  assign sck_oe_o    = mstr_on_w;
  assign mosi_oe_o   = mstr_on_w;
  assign port_o      = pdat_q;
  assign port_oe_o   = pdir_q;
  assign done_irq_o  = ctrl_q[C_IRQEN] && flags_w[F_DONE];
  assign fault_irq_o = ctrl_q[C_IRQEN] && flags_w[F_FAULT];

  a_r7_fault_drops_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_w[F_FAULT]) |-> !ctrl_q[C_EN] && !ctrl_q[C_MSTR] && !sck_oe_o);
  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[C_IRQEN] |-> !done_irq_o && !fault_irq_o);
  a_r9_idle_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_w && !mstr_on_w && !busy_w |=> !busy_w);
  a_r6_coll_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_w && busy_w |=> stat_w[S_COLL] && busy_w);
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  localparam logic [4:0] A_CTRL = 5'h00, A_BAUD = 5'h04, A_STAT = 5'h05,
                         A_DATA = 5'h09, A_PDAT = 5'h0D, A_PDIR = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sck, sck_oe, mosi, mosi_oe, done_irq, fault_irq;
  logic miso = 1'b0, ss_n = 1'b1;
  logic [7:0] port, port_oe;

  int checks = 0, errors = 0, cyc = 0;
  bit s_act = 0, s_cpha = 0, s_lsb = 0;
  int s_e = 0, s_k;
  logic [7:0] s_tx = '0, s_rx = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_byte_master u_spi_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .sck_oe_o(sck_oe),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso), .ss_ni(ss_n),
    .port_o(port), .port_oe_o(port_oe), .done_irq_o(done_irq), .fault_irq_o(fault_irq)
  );

  function automatic logic bitof(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  // slave model: samples MOSI and drives MISO from its own edge count
  always @(sck) begin
    if (s_act) begin
      #1;
      s_e = s_e + 1;
      if (s_cpha ? (s_e % 2 == 0) : (s_e % 2 == 1)) begin
        s_k = (s_e - 1) / 2;
        if (s_lsb) s_rx[s_k] = mosi; else s_rx[7-s_k] = mosi;
      end else begin
        s_k = s_cpha ? (s_e - 1) / 2 : s_e / 2;
        if (s_k < 8) miso = bitof(s_tx, s_k, s_lsb);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_after(input int t);
    while (cyc < t) begin @(posedge clk); #1; end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic arm_slave(input logic [7:0] stx, input bit cpha, input bit lsb);
    s_act = 0; s_e = 0; s_rx = '0; s_tx = stx; s_cpha = cpha; s_lsb = lsb;
    if (!cpha) miso = bitof(stx, 0, lsb);
    s_act = 1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(A_STAT, v); chk("R1 status", v, 8'h00);
    bus_rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    bus_rd(A_BAUD, v); chk("R1 baud", v, 8'h00);
    chk("R1 pins", {sck, sck_oe, mosi_oe, done_irq, fault_irq}, 0);
    chk("R1 port_oe", port_oe, 8'h00);
  endtask

  task automatic t_xfer(input logic [7:0] tx, input logic [7:0] stx, input bit cpol,
                        input bit cpha, input bit lsb, input logic [7:0] baud, input bit irq);
    logic [7:0] v;
    int h, w;
    h = (((baud >> 4) & 7) + 1) << (baud & 7);
    bus_wr(A_CTRL, {irq, 1'b1, 1'b0, 1'b1, cpol, cpha, 1'b0, lsb});
    bus_wr(A_BAUD, baud);
    arm_slave(stx, cpha, lsb);
    bus_wr(A_DATA, tx); w = cyc;
    wait_after(w + h - 1); chk("R2 before first edge", sck, cpol);
    wait_after(w + h);     chk("R2 first edge", sck, !cpol);
    wait_after(w + 16 * h + 1);
    chk("R2 edge count", s_e, 16);
    chk("R3 sck rest", sck, cpol);
    chk("R3 order seen by slave", s_rx, tx);
    chk("R8 done irq", done_irq, irq);
    bus_rd(A_STAT, v); chk("R5 done flag", v, 8'h80);
    bus_rd(A_DATA, v); chk("R4 rx byte", v, stx);
    bus_rd(A_STAT, v); chk("R5 cleared", v, 8'h00);
    chk("R8 irq after clear", done_irq, 0);
    s_act = 0;
  endtask

  task automatic t_no_clear_without_status;
    logic [7:0] v;
    bus_wr(A_CTRL, 8'h50); bus_wr(A_BAUD, 8'h00);
    bus_wr(A_DATA, 8'h11); wait_after(cyc + 20);
    bus_rd(A_DATA, v);
    bus_rd(A_STAT, v); chk("R5 data read alone keeps flag", v, 8'h80);
    bus_rd(A_DATA, v);
    bus_rd(A_STAT, v); chk("R5 sequence clears", v, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    int w;
    bus_wr(A_CTRL, 8'h50); bus_wr(A_BAUD, 8'h03);
    arm_slave(8'h3C, 0, 0);
    bus_wr(A_DATA, 8'hA5); w = cyc;
    wait_after(w + 20);
    bus_wr(A_DATA, 8'hFF);
    wait_after(w + 16 * 8 + 1);
    chk("R6 edges undisturbed", s_e, 16);
    chk("R6 dropped byte", s_rx, 8'hA5);
    bus_rd(A_STAT, v); chk("R6 collision flag", v, 8'hC0);
    bus_rd(A_DATA, v); chk("R6 rx byte", v, 8'h3C);
    bus_rd(A_STAT, v); chk("R6 flags cleared", v, 8'h00);
    s_act = 0;
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    bus_wr(A_CTRL, 8'h00); wait_after(cyc + 3);
    arm_slave(8'h00, 0, 0);
    bus_wr(A_DATA, 8'h77); wait_after(cyc + 40);
    chk("R9 no edges", s_e, 0);
    bus_rd(A_STAT, v); chk("R9 no flag", v, 8'h00);
    bus_rd(A_DATA, v); chk("R9 rx unchanged", v, 8'h3C);
    s_act = 0;
  endtask

  task automatic t_fault;
    logic [7:0] v;
    bus_wr(A_CTRL, 8'hD0); bus_wr(A_BAUD, 8'h03);
    bus_wr(A_DATA, 8'h5A); wait_after(cyc + 10);
    ss_n = 1'b0; wait_after(cyc + 6);
    chk("R7 drivers released", {sck_oe, mosi_oe}, 0);
    chk("R7 sck back to rest", sck, 0);
    chk("R8 fault irq", fault_irq, 1);
    ss_n = 1'b1; wait_after(cyc + 4);
    bus_rd(A_STAT, v); chk("R7 fault flag", v, 8'h10);
    bus_rd(A_CTRL, v); chk("R7 master cleared", v, 8'h80);
    bus_wr(A_CTRL, 8'hD0); wait_after(cyc + 2);
    bus_rd(A_STAT, v); chk("R7 fault cleared", v, 8'h00);
    chk("R7 drivers back", {sck_oe, mosi_oe, fault_irq}, 3'b110);
  endtask

  task automatic t_port;
    logic [7:0] v;
    bus_wr(A_PDIR, 8'h0E); bus_wr(A_PDAT, 8'h08);
    chk("R10 port enables", port_oe, 8'h0E);
    chk("R10 select deasserted", port[3], 1);
    bus_wr(A_PDAT, 8'h00);
    chk("R10 select asserted", port[3], 0);
    bus_rd(A_PDIR, v); chk("R10 dir readback", v, 8'h0E);
  endtask

  task automatic t_race;
    logic [7:0] v;
    int w;
    bus_wr(A_CTRL, 8'h50); bus_wr(A_BAUD, 8'h00);
    bus_wr(A_DATA, 8'h21); wait_after(cyc + 20);
    bus_rd(A_STAT, v); chk("R11 armed", v, 8'h80);
    bus_wr(A_DATA, 8'h42); w = cyc;
    wait_after(w + 15);
    bus_rd(A_DATA, v);   // lands on the 16th edge
    bus_rd(A_STAT, v); chk("R11 set wins", v, 8'h80);
    bus_rd(A_DATA, v);
    bus_rd(A_STAT, v); chk("R11 later clear", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_after(cyc + 2);
    t_reset();
    t_xfer(8'hA3, 8'h5C, 0, 0, 0, 8'h00, 1);
    t_xfer(8'h96, 8'h1E, 1, 1, 1, 8'h12, 0);
    t_xfer(8'hC1, 8'h83, 0, 1, 0, 8'h01, 1);
    t_xfer(8'h0F, 8'hF2, 1, 0, 1, 8'h20, 0);
    t_no_clear_without_status();
    t_collision();
    t_ignored();
    t_fault();
    t_port();
    t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule